// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller sits beside a volatile working array that has a nonvolatile shadow copy. It decides when the array is copied into the shadow (a store) and when the shadow is copied back (a recall). It gates the memory port while either transfer runs. A store can start from three sources: a shared active-low request/busy line, a one-cycle software command, and a digital power-fail flag. A recall starts from a one-cycle request.

The block keeps a dirty latch that records whether a write has completed since the last transfer. Stores from the request line and from power-fail run only when that latch is set. A software store always runs. When the request line falls, the block waits a fixed delay so that accesses already in flight can finish, and it refuses new writes during that wait. While a store runs, the block pulls the shared line low through an open-drain style enable. The transfer is modelled as a countdown of fixed length. A saturating counter tracks store endurance.

Top module: `nvseq_top`

## Requirements
- R1: `dirty` goes high the cycle after a `wrDone` pulse that arrives while `wrInhibit` is low. A `wrDone` pulse while `wrInhibit` is high is ignored. `dirty` clears when a store or a recall finishes.
- R2: With `dirty` low, a low level on `lineSense` starts no store and `pwrFail` starts no store. `busyDriveLow` stays 0 in both cases.
- R3: A `swStore` pulse in the idle state starts a store even when `dirty` is low.
- R4: When `lineSense` is seen low with `dirty` high, reads remain allowed (`rdInhibit`=0) for DELAY_CYCLES cycles. `busyDriveLow` rises in the cycle after that.
- R5: `wrInhibit` is 1 whenever `lineSense` is low, and it stays 1 for the whole delay window.
- R6: `busyDriveLow` is 1 for exactly STORE_CYCLES cycles per store, whatever started the store. `storeDone` pulses in the last of those cycles.
- R7: When `lineSense` is low with `dirty` low, `busyDriveLow` stays 0. `rdInhibit` and `wrInhibit` stay 1 until `lineSense` returns high.
- R8: During a store and during a recall, `rdInhibit` and `wrInhibit` are both 1.
- R9: A `recallReq` pulse runs a recall of RECALL_CYCLES cycles with `busyDriveLow` at 0. `recallDone` pulses in its last cycle, and `storeCount` is left unchanged.
- R10: `storeCount` rises by one per finished store and saturates at STORE_LIMIT. `wornOut` is 1 when the count equals STORE_LIMIT.
- R11: In the idle state, the start priority is `pwrFail` (with `dirty` high) first, then a low `lineSense`, then `swStore`, then `recallReq`. A power-fail store skips the delay, so `busyDriveLow` is 1 in the cycle after the trigger. A request that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lineSense | input | 1 | Sensed level of the shared request/busy line (0 = low) |
| swStore | input | 1 | One-cycle software store command |
| recallReq | input | 1 | One-cycle recall request |
| pwrFail | input | 1 | Digital power-fail flag (level) |
| wrDone | input | 1 | Pulse marking a completed array write |
| busyDriveLow | output | 1 | Enable that pulls the shared line low |
| rdInhibit | output | 1 | Blocks array reads |
| wrInhibit | output | 1 | Blocks array writes |
| storeDone | output | 1 | Pulse in the last cycle of a store |
| recallDone | output | 1 | Pulse in the last cycle of a recall |
| dirty | output | 1 | Dirty latch state |
| storeCount | output | CNT_W | Saturating count of finished stores |
| wornOut | output | 1 | Count has reached STORE_LIMIT |

## Verification
The assertions assume that `wrDone` only arrives for writes the memory port actually made. They also assume that `lineSense` is the wired-AND of an external driver and the block's own `busyDriveLow`. The bench builds `lineSense` that way and raises `wrDone` only as single-cycle pulses. One of those pulses is placed deliberately inside a recall to test that it is ignored. Command pulses are driven at the falling edge and last one cycle. They are issued only when the block is idle, except in the case that tests priority on purpose.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DELAY,
    ST_STORE,
    ST_RECALL,
    ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic loadDelay;
    logic loadStore;
    logic loadRecall;
    logic clrDirty;
    logic bumpCount;
  } seqStrobe_t;
endpackage

// File: rtl/nvseq_ctrl.sv
module nvseq_ctrl
  import nvseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lineSense,
  input  logic       swStore,
  input  logic       recallReq,
  input  logic       pwrFail,
  input  logic       dirty,
  input  logic       cntZero,
  output seqStrobe_t strobe,
  output logic       busyDriveLow,
  output logic       rdInhibit,
  output logic       wrInhibit,
  output logic       storeDone,
  output logic       recallDone
);
  seqState_t curState, nxtState;
  logic lineLow;

  assign lineLow = ~lineSense;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) curState <= ST_IDLE;
    else        curState <= nxtState;
  end

  always_comb begin
    nxtState   = curState;
    strobe     = '0;
    storeDone  = 1'b0;
    recallDone = 1'b0;
    unique case (curState)
      ST_IDLE: begin
        if (pwrFail && dirty) begin
          nxtState         = ST_STORE;
          strobe.loadStore = 1'b1;
        end else if (lineLow) begin
          if (dirty) begin
            nxtState         = ST_DELAY;
            strobe.loadDelay = 1'b1;
          end else begin
            nxtState = ST_HOLD;
          end
        end else if (swStore) begin
          nxtState         = ST_STORE;
          strobe.loadStore = 1'b1;
        end else if (recallReq) begin
          nxtState          = ST_RECALL;
          strobe.loadRecall = 1'b1;
        end
      end
      ST_DELAY: begin
        if (cntZero) begin
          nxtState         = ST_STORE;
          strobe.loadStore = 1'b1;
        end
      end
      ST_STORE: begin
        if (cntZero) begin
          nxtState         = ST_IDLE;
          strobe.clrDirty  = 1'b1;
          strobe.bumpCount = 1'b1;
          storeDone        = 1'b1;
        end
      end
      ST_RECALL: begin
        if (cntZero) begin
          nxtState        = ST_IDLE;
          strobe.clrDirty = 1'b1;
          recallDone      = 1'b1;
        end
      end
      ST_HOLD: begin
        if (!lineLow) nxtState = ST_IDLE;
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign busyDriveLow = (curState == ST_STORE);
  assign rdInhibit    = (curState == ST_STORE) || (curState == ST_RECALL) ||
                        (curState == ST_HOLD);
  assign wrInhibit    = rdInhibit || (curState == ST_DELAY) || lineLow;

  // R2
  skip_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_IDLE && !dirty && !swStore) |=> curState != ST_STORE);

  // R11
  pwr_no_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_IDLE && pwrFail && dirty) |=> busyDriveLow);

  // R7
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (curState == ST_HOLD && lineLow) |=> (rdInhibit && !busyDriveLow));
endmodule

// File: rtl/nvseq_datapath.sv
module nvseq_datapath
  import nvseq_pkg::*;
#(
  parameter int DELAY_CYCLES  = 8,
  parameter int STORE_CYCLES  = 64,
  parameter int RECALL_CYCLES = 32,
  parameter int STORE_LIMIT   = 200000,
  localparam int MAX_LEN = (DELAY_CYCLES > STORE_CYCLES)
                         ? ((DELAY_CYCLES > RECALL_CYCLES) ? DELAY_CYCLES : RECALL_CYCLES)
                         : ((STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES),
  localparam int TMR_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1,
  localparam int CNT_W = $clog2(STORE_LIMIT + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  seqStrobe_t       strobe,
  input  logic             wrDone,
  input  logic             wrInhibit,
  output logic             cntZero,
  output logic             dirty,
  output logic [CNT_W-1:0] storeCount,
  output logic             wornOut
);
  localparam logic [TMR_W-1:0] DELAY_LD  = TMR_W'(DELAY_CYCLES - 1);
  localparam logic [TMR_W-1:0] STORE_LD  = TMR_W'(STORE_CYCLES - 1);
  localparam logic [TMR_W-1:0] RECALL_LD = TMR_W'(RECALL_CYCLES - 1);
  localparam logic [CNT_W-1:0] LIMIT_V   = CNT_W'(STORE_LIMIT);

  logic [TMR_W-1:0] phaseTmr;
  logic wrOk;

  assign wrOk = wrDone && !wrInhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 phaseTmr <= '0;
    else if (strobe.loadDelay)  phaseTmr <= DELAY_LD;
    else if (strobe.loadStore)  phaseTmr <= STORE_LD;
    else if (strobe.loadRecall) phaseTmr <= RECALL_LD;
    else if (phaseTmr != '0)    phaseTmr <= phaseTmr - 1'b1;
  end
  assign cntZero = (phaseTmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               dirty <= 1'b0;
    else if (strobe.clrDirty) dirty <= 1'b0;
    else if (wrOk)            dirty <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) storeCount <= '0;
    else if (strobe.bumpCount && storeCount != LIMIT_V)
      storeCount <= storeCount + 1'b1;
  end
  assign wornOut = (storeCount == LIMIT_V);

  // R1
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrDone && !wrInhibit && !strobe.clrDirty) |=> dirty);

  // R1
  dirty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrDirty |=> !dirty);

  // R10
  count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    storeCount <= LIMIT_V);

  // R10
  count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.bumpCount |=> $stable(storeCount));
endmodule

// File: rtl/nvseq_top.sv
module nvseq_top
  import nvseq_pkg::*;
#(
  parameter int DELAY_CYCLES  = 8,
  parameter int STORE_CYCLES  = 64,
  parameter int RECALL_CYCLES = 32,
  parameter int STORE_LIMIT   = 200000,
  localparam int CNT_W = $clog2(STORE_LIMIT + 1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lineSense,
  input  logic             swStore,
  input  logic             recallReq,
  input  logic             pwrFail,
  input  logic             wrDone,
  output logic             busyDriveLow,
  output logic             rdInhibit,
  output logic             wrInhibit,
  output logic             storeDone,
  output logic             recallDone,
  output logic             dirty,
  output logic [CNT_W-1:0] storeCount,
  output logic             wornOut
);
  seqStrobe_t strobe;
  logic cntZero;

  nvseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .lineSense(lineSense), .swStore(swStore),
    .recallReq(recallReq), .pwrFail(pwrFail), .dirty(dirty), .cntZero(cntZero),
    .strobe(strobe), .busyDriveLow(busyDriveLow), .rdInhibit(rdInhibit),
    .wrInhibit(wrInhibit), .storeDone(storeDone), .recallDone(recallDone)
  );

  nvseq_datapath #(
    .DELAY_CYCLES(DELAY_CYCLES), .STORE_CYCLES(STORE_CYCLES),
    .RECALL_CYCLES(RECALL_CYCLES), .STORE_LIMIT(STORE_LIMIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrDone(wrDone),
    .wrInhibit(wrInhibit), .cntZero(cntZero), .dirty(dirty),
    .storeCount(storeCount), .wornOut(wornOut)
  );

  // R8
  busy_inhibits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busyDriveLow |-> (rdInhibit && wrInhibit));

  // R6
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    storeDone |-> busyDriveLow);

  // R9
  recall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recallDone |-> (!busyDriveLow && rdInhibit));
endmodule

// File: tb/sim_nvseq_top.sv
module sim_nvseq_top;
  localparam int DLY = 4;
  localparam int STC = 6;
  localparam int RCC = 5;
  localparam int LIM = 3;
  localparam int CW  = $clog2(LIM + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic extLow = 1'b0;
  logic swStore = 1'b0, recallReq = 1'b0, pwrFail = 1'b0, wrDone = 1'b0;
  logic busyDriveLow, rdInhibit, wrInhibit, storeDone, recallDone, dirty, wornOut;
  logic [CW-1:0] storeCount;
  logic lineSense;

  int nChecks = 0;
  int nFails = 0;
  int expQ[$];

  assign lineSense = ~(extLow | busyDriveLow);

  always #10 clk = ~clk;

  nvseq_top #(.DELAY_CYCLES(DLY), .STORE_CYCLES(STC), .RECALL_CYCLES(RCC),
              .STORE_LIMIT(LIM)) u0 (
    .clk(clk), .rst_n(rst_n), .lineSense(lineSense), .swStore(swStore),
    .recallReq(recallReq), .pwrFail(pwrFail), .wrDone(wrDone),
    .busyDriveLow(busyDriveLow), .rdInhibit(rdInhibit), .wrInhibit(wrInhibit),
    .storeDone(storeDone), .recallDone(recallDone), .dirty(dirty),
    .storeCount(storeCount), .wornOut(wornOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic checkEq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  // expected item: kind*16 + count before completion (kind 1 = store, 2 = recall)
  task automatic expectDone(input int kind, input int cnt);
    expQ.push_back(kind * 16 + cnt);
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseWrite();
    wrDone = 1'b1;
    tick(1);
    wrDone = 1'b0;
  endtask

  task automatic waitBusyEnd();
    for (int i = 0; i < 200 && busyDriveLow; i++) @(negedge clk);
  endtask

  task automatic waitReadFree();
    for (int i = 0; i < 200 && rdInhibit; i++) @(negedge clk);
  endtask

  // monitor: pops the scoreboard at each completion pulse
  always @(negedge clk) begin
    if (rst_n && (storeDone || recallDone)) begin
      int got;
      got = (storeDone ? 1 : 2) * 16 + int'(storeCount);
      if (expQ.size() == 0) begin
        check(1'b0, "R6/R9 unexpected done", got, -1);
      end else begin
        int want;
        want = expQ.pop_front();
        checkEq("R6/R9/R10 done item", got, want);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    checkEq("reset busy", busyDriveLow, 0);
    checkEq("reset rd", rdInhibit, 0);
    checkEq("reset wr", wrInhibit, 0);
    checkEq("R1 reset dirty", dirty, 0);
    checkEq("R10 reset count", storeCount, 0);

    // R3: software store with clean latch
    expectDone(1, 0);
    swStore = 1'b1;
    tick(1);
    swStore = 1'b0;
    checkEq("R3 sw store busy", busyDriveLow, 1);
    checkEq("R8 store rd inhibit", rdInhibit, 1);
    checkEq("R8 store wr inhibit", wrInhibit, 1);
    begin
      int len = 1;
      for (int i = 0; i < 50 && busyDriveLow; i++) begin
        tick(1);
        if (busyDriveLow) len++;
      end
      checkEq("R6 store length", len, STC);
    end
    checkEq("R10 count after one", storeCount, 1);

    // R7/R2: external low with clean latch
    extLow = 1'b1;
    tick(2);
    checkEq("R7 no busy drive", busyDriveLow, 0);
    checkEq("R7 rd held", rdInhibit, 1);
    checkEq("R7 wr held", wrInhibit, 1);
    tick(3);
    checkEq("R2 hw clean skipped", busyDriveLow, 0);
    checkEq("R7 still held", rdInhibit, 1);
    extLow = 1'b0;
    tick(2);
    checkEq("R7 released rd", rdInhibit, 0);
    checkEq("R7 released wr", wrInhibit, 0);

    // R1 + R4/R5: dirty hardware store with delay
    pulseWrite();
    checkEq("R1 dirty set", dirty, 1);
    expectDone(1, 1);
    extLow = 1'b1;
    tick(1);
    checkEq("R5 wr blocked at fall", wrInhibit, 1);
    checkEq("R4 reads allowed", rdInhibit, 0);
    tick(DLY - 1);
    checkEq("R4 last delay no busy", busyDriveLow, 0);
    checkEq("R5 wr blocked in delay", wrInhibit, 1);
    checkEq("R4 rd free in delay", rdInhibit, 0);
    tick(1);
    checkEq("R4 busy after delay", busyDriveLow, 1);
    waitBusyEnd();
    tick(1);
    checkEq("R1 dirty cleared by store", dirty, 0);
    checkEq("R10 count two", storeCount, 2);
    checkEq("R7 hold after hw store", rdInhibit, 1);
    extLow = 1'b0;
    tick(2);

    // R9: recall, with an ignored write inside
    pulseWrite();
    expectDone(2, 2);
    recallReq = 1'b1;
    tick(1);
    recallReq = 1'b0;
    checkEq("R9 recall no busy", busyDriveLow, 0);
    checkEq("R8 recall rd inhibit", rdInhibit, 1);
    checkEq("R8 recall wr inhibit", wrInhibit, 1);
    tick(1);
    pulseWrite();
    waitReadFree();
    tick(1);
    checkEq("R1 write in recall ignored", dirty, 0);
    checkEq("R9 count unchanged", storeCount, 2);

    // R2: power fail with clean latch
    pwrFail = 1'b1;
    tick(3);
    checkEq("R2 pwr clean no busy", busyDriveLow, 0);
    checkEq("R2 pwr clean no inhibit", rdInhibit, 0);
    pwrFail = 1'b0;
    tick(1);

    // R11: power fail wins over sw and recall, no delay
    pulseWrite();
    expectDone(1, 2);
    pwrFail = 1'b1;
    swStore = 1'b1;
    recallReq = 1'b1;
    tick(1);
    swStore = 1'b0;
    recallReq = 1'b0;
    checkEq("R11 pwr immediate busy", busyDriveLow, 1);
    waitBusyEnd();
    tick(3);
    checkEq("R11 losing recall dropped", rdInhibit, 0);
    checkEq("R10 count at limit", storeCount, LIM);
    checkEq("R10 worn out", wornOut, 1);
    pwrFail = 1'b0;
    tick(1);

    // R10: saturation
    expectDone(1, LIM);
    swStore = 1'b1;
    tick(1);
    swStore = 1'b0;
    waitBusyEnd();
    tick(1);
    checkEq("R10 saturated", storeCount, LIM);
    checkEq("R10 still worn", wornOut, 1);

    tick(2);
    checkEq("R6/R9 scoreboard drained", expQ.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule